// File: doc/BRIEF.md
# Three-Source Raster Logic Datapath

This block is the word-level combining stage of a two-dimensional raster engine. On each accepted step it takes one word from each of three source channels (a mask channel A, an image channel B and a background channel C) and produces one destination word D. Channels A and B each pass through their own barrel shifter. The bits that leave one word are carried into the next word of the same channel within a row, so an image can be placed at any pixel offset inside the word grid.

The A word is trimmed by an edge mask on the first word of a row and by a second edge mask on the last word of a row. Each bit of D is then looked up in an 8-entry truth table, the function byte, indexed by the matching bits of A, B and C. This gives any Boolean function of three inputs: copy, clear, set, masked compositing, exclusive-or, and so on.

A controller outside the block walks the rectangle. It presents words in row order with first/last-of-row flags and consumes D through a valid/ready handshake. A source channel that is switched off supplies a held constant instead of fetched data.

Top module: `rop3_word_path`

## Requirements
- R1: Bit i of D equals bit k of `func`, where k = 4·A[i] + 2·B[i] + C[i]. A, B and C here are the processed channel words, so A=B=C=1 selects func bit 7 and A=B=C=0 selects func bit 0.
- R2: With unshifted, unmasked inputs, func 8'h00 gives all zeros, 8'hFF gives all ones, 8'hF0 gives A, 8'hCC gives B, 8'hAA gives C, and 8'hCA gives (A AND B) OR (NOT A AND C).
- R3: With `descend`=0, a channel word with shift s (0..W-1) becomes the W low bits of {previous word of that channel, current word} shifted right by s. The vacated high bits are filled from the low bits of the previous word. A and B shift independently.
- R4: On a word with `first_word`=1 the previous-word carry is taken as zero, so no bits from an earlier row enter the new row.
- R5: With `descend`=1 the shift runs left. The result is the W high bits of {current word, previous word} shifted left by s, and the vacated low bits come from the high bits of the previous word.
- R6: The A word is ANDed with `first_mask` when `first_word`=1 and with `last_mask` when `last_word`=1, and with both when both flags are set. Masking happens before the shift, so the masked word is also what is carried into the next word.
- R7: Channel C is never shifted: `a_shift`, `b_shift` and `descend` have no effect on the C bits used by the truth table.
- R8: When `use_a`, `use_b` or `use_c` is 0, that channel uses `hold_a`, `hold_b` or `hold_c` in place of the input word, and the fetched word has no effect.
- R9: A word is accepted when `in_valid` and `in_ready` are both 1. Its D appears with `out_valid`=1 on the next cycle. `in_ready` = !`out_valid` OR `out_ready`. While `out_valid`=1 and `out_ready`=0, D and `out_valid` hold.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word set is valid |
| in_ready | output | 1 | Datapath can accept a word |
| first_word | input | 1 | Word is the first of its row |
| last_word | input | 1 | Word is the last of its row |
| descend | input | 1 | 1 = left shift (descending walk), 0 = right shift |
| func | input | 8 | Truth table, indexed by {A,B,C} |
| use_a | input | 1 | Channel A takes fetched data when 1 |
| use_b | input | 1 | Channel B takes fetched data when 1 |
| use_c | input | 1 | Channel C takes fetched data when 1 |
| hold_a | input | W | Constant for channel A when disabled |
| hold_b | input | W | Constant for channel B when disabled |
| hold_c | input | W | Constant for channel C when disabled |
| a_word | input | W | Mask channel word |
| b_word | input | W | Image channel word |
| c_word | input | W | Background channel word |
| a_shift | input | log2(W) | Shift amount for A |
| b_shift | input | log2(W) | Shift amount for B |
| first_mask | input | W | Edge mask for A on the first word of a row |
| last_mask | input | W | Edge mask for A on the last word of a row |
| out_valid | output | 1 | D word is valid |
| out_ready | input | 1 | Consumer takes D |
| d_word | output | W | Destination word |

## Verification
The bound checker watches the handshake on every cycle: accept leads to valid, a stalled output holds, and an empty stage is always ready. It also checks the fixed function codes at the ports: clear, set, pass-through of C or its held constant, and unshifted B. The carry across words, the row-start clearing of the carry, the descending direction and the ordering of masking before the shift depend on a history of several words. Only the bench shows those, with its directed rows and randomized stalled streams compared against the reference model.

// File: rtl/rop3_pkg.sv
package rop3_pkg;
   localparam int unsigned SHIFT_CH = 2;
   localparam int unsigned CH_MASK  = 0;
   localparam int unsigned CH_IMG   = 1;
   localparam logic [7:0] FN_CLEAR  = 8'h00;
   localparam logic [7:0] FN_SET    = 8'hFF;
   localparam logic [7:0] FN_PASS_A = 8'hF0;
   localparam logic [7:0] FN_PASS_B = 8'hCC;
   localparam logic [7:0] FN_PASS_C = 8'hAA;
   localparam logic [7:0] FN_STENCIL = 8'hCA;
endpackage

// File: rtl/rop3_edge_mask.sv
module rop3_edge_mask #(
   parameter int unsigned W = 16
) (
   input  logic         enable,
   input  logic [W-1:0] fetched,
   input  logic [W-1:0] constant,
   input  logic         head,
   input  logic         tail,
   input  logic [W-1:0] head_mask,
   input  logic [W-1:0] tail_mask,
   output logic [W-1:0] trimmed
);
   logic [W-1:0] chosen;
   logic [W-1:0] head_gate;
   logic [W-1:0] tail_gate;

   always_comb begin
      chosen    = enable ? fetched : constant;
      head_gate = head ? head_mask : {W{1'b1}};
      tail_gate = tail ? tail_mask : {W{1'b1}};
      trimmed   = chosen & head_gate & tail_gate;
   end
endmodule

// File: rtl/rop3_shift.sv
module rop3_shift #(
   parameter int unsigned W   = 16,
   localparam int unsigned SHW = $clog2(W)
) (
   input  logic [W-1:0]   cur,
   input  logic [W-1:0]   prev,
   input  logic [SHW-1:0] amt,
   input  logic           left,
   input  logic           row_start,
   output logic [W-1:0]   result
);
   logic [W-1:0]   carry;
   logic [2*W-1:0] right_cat;
   logic [2*W-1:0] left_cat;

   always_comb begin
      carry     = row_start ? '0 : prev;
      right_cat = {carry, cur} >> amt;
      left_cat  = {cur, carry} << amt;
      if (left)
         result = left_cat[2*W-1:W];
      else
         result = right_cat[W-1:0];
   end

   logic unused_bits;
   assign unused_bits = ^{right_cat[2*W-1:W], left_cat[W-1:0]};
endmodule

// File: rtl/rop3_truth.sv
module rop3_truth #(
   parameter int unsigned W = 16
) (
   input  logic [7:0]   table_bits,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] d
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign d[i] = table_bits[{a[i], b[i], c[i]}];
   end
endmodule

// File: rtl/rop3_word_path.sv
module rop3_word_path
   import rop3_pkg::*;
#(
   parameter int unsigned W   = 16,
   localparam int unsigned SHW = $clog2(W)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic           first_word,
   input  logic           last_word,
   input  logic           descend,
   input  logic [7:0]     func,
   input  logic           use_a,
   input  logic           use_b,
   input  logic           use_c,
   input  logic [W-1:0]   hold_a,
   input  logic [W-1:0]   hold_b,
   input  logic [W-1:0]   hold_c,
   input  logic [W-1:0]   a_word,
   input  logic [W-1:0]   b_word,
   input  logic [W-1:0]   c_word,
   input  logic [SHW-1:0] a_shift,
   input  logic [SHW-1:0] b_shift,
   input  logic [W-1:0]   first_mask,
   input  logic [W-1:0]   last_mask,
   output logic           out_valid,
   input  logic           out_ready,
   output logic [W-1:0]   d_word
);
   initial begin : elab_chk
      assert (W >= 2 && (W & (W - 1)) == 0)
         else $error("rop3_word_path: W must be a power of two, at least 2");
   end

   logic           take;
   logic [W-1:0]   src_raw  [SHIFT_CH];
   logic [W-1:0]   src_prev [SHIFT_CH];
   logic [W-1:0]   src_out  [SHIFT_CH];
   logic [SHW-1:0] src_amt  [SHIFT_CH];
   logic [W-1:0]   c_eff;
   logic [W-1:0]   d_next;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   rop3_edge_mask #(.W(W)) u_mask_a (
      .enable   (use_a),
      .fetched  (a_word),
      .constant (hold_a),
      .head     (first_word),
      .tail     (last_word),
      .head_mask(first_mask),
      .tail_mask(last_mask),
      .trimmed  (src_raw[CH_MASK])
   );

   assign src_raw[CH_IMG]  = use_b ? b_word : hold_b;
   assign src_amt[CH_MASK] = a_shift;
   assign src_amt[CH_IMG]  = b_shift;
   assign c_eff            = use_c ? c_word : hold_c;

   for (genvar k = 0; k < SHIFT_CH; k++) begin : g_chan
      always_ff @(posedge clk) begin
         if (!rst_n)
            src_prev[k] <= '0;
         else if (take)
            src_prev[k] <= src_raw[k];
      end

      rop3_shift #(.W(W)) u_shift (
         .cur      (src_raw[k]),
         .prev     (src_prev[k]),
         .amt      (src_amt[k]),
         .left     (descend),
         .row_start(first_word),
         .result   (src_out[k])
      );
   end

   rop3_truth #(.W(W)) u_truth (
      .table_bits(func),
      .a         (src_out[CH_MASK]),
      .b         (src_out[CH_IMG]),
      .c         (c_eff),
      .d         (d_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         d_word    <= '0;
      end else if (take) begin
         out_valid <= 1'b1;
         d_word    <= d_next;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/rop3_word_path_chk.sv
module rop3_word_path_chk #(
   parameter int unsigned W   = 16,
   localparam int unsigned SHW = $clog2(W)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic           in_ready,
   input logic [7:0]     func,
   input logic           use_b,
   input logic           use_c,
   input logic [W-1:0]   hold_c,
   input logic [W-1:0]   b_word,
   input logic [W-1:0]   c_word,
   input logic [SHW-1:0] b_shift,
   input logic           out_valid,
   input logic           out_ready,
   input logic [W-1:0]   d_word
);
   logic acc;
   assign acc = in_valid && in_ready;

   AST_CLEAR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      acc && func == 8'h00 |=> d_word == '0); // R2
   AST_SET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      acc && func == 8'hFF |=> d_word == {W{1'b1}}); // R2
   AST_PASS_C: assert property (@(posedge clk) disable iff (!rst_n)
      acc && func == 8'hAA && use_c |=> d_word == $past(c_word)); // R7
   AST_HELD_C: assert property (@(posedge clk) disable iff (!rst_n)
      acc && func == 8'hAA && !use_c |=> d_word == $past(hold_c)); // R8
   AST_PASS_B_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      acc && func == 8'hCC && use_b && b_shift == '0 |=> d_word == $past(b_word)); // R3
   AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> out_valid); // R9
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(d_word)); // R9
   AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready); // R9
endmodule

bind rop3_word_path rop3_word_path_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .func     (func),
   .use_b    (use_b),
   .use_c    (use_c),
   .hold_c   (hold_c),
   .b_word   (b_word),
   .c_word   (c_word),
   .b_shift  (b_shift),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .d_word   (d_word)
);

// File: tb/tb_rop3_word_path.sv
`timescale 1ns/1ps
module tb_rop3_word_path;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, in_ready, first_word, last_word, descend;
   logic [7:0]  func;
   logic        use_a, use_b, use_c;
   logic [15:0] hold_a, hold_b, hold_c, a_word, b_word, c_word;
   logic [3:0]  a_shift, b_shift;
   logic [15:0] first_mask, last_mask;
   logic        out_valid, out_ready;
   logic [15:0] d_word;

   always #5 clk = ~clk;

   rop3_word_path #(.W(16)) dut (.*);

   int checks = 0;
   int fails  = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];
   string       cur_tag = "R10";
   logic [15:0] m_prev_a = '0, m_prev_b = '0;
   bit          rnd_ready = 0;
   bit          was_stalled = 0;
   logic [15:0] stalled_val;

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] shf(logic [15:0] cur, logic [15:0] prev,
                                       int sh, bit left);
      logic [31:0] t;
      if (!left) begin
         t = {prev, cur};
         t = t >> sh;
         return t[15:0];
      end
      t = {cur, prev};
      t = t << sh;
      return t[31:16];
   endfunction

   function automatic logic [15:0] lookup(logic [7:0] f, logic [15:0] a,
                                          logic [15:0] b, logic [15:0] c);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) begin
         int k;
         k = 4 * int'(a[i]) + 2 * int'(b[i]) + int'(c[i]);
         r[i] = f[k];
      end
      return r;
   endfunction

   task automatic model_accept();
      logic [15:0] a, b, c, pa, pb;
      a = use_a ? a_word : hold_a;
      if (first_word) a = a & first_mask;
      if (last_word)  a = a & last_mask;
      b = use_b ? b_word : hold_b;
      c = use_c ? c_word : hold_c;
      pa = first_word ? 16'h0 : m_prev_a;
      pb = first_word ? 16'h0 : m_prev_b;
      exp_q.push_back(lookup(func, shf(a, pa, int'(a_shift), descend),
                             shf(b, pb, int'(b_shift), descend), c));
      tag_q.push_back(cur_tag);
      m_prev_a = a;
      m_prev_b = b;
   endtask

   task automatic observe();
      if (was_stalled) begin
         check("R9 stall hold valid", {15'h0, out_valid}, 16'h1);
         check("R9 stall hold data", d_word, stalled_val);
      end
      was_stalled = out_valid && !out_ready;
      stalled_val = d_word;
      check("R9 ready rule", {15'h0, in_ready}, {15'h0, (!out_valid || out_ready)});
      if (out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check("R9 unexpected output", d_word, 16'hxxxx);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, d_word, e);
         end
      end
      if (in_valid && in_ready) model_accept();
   endtask

   task automatic step(output bit acc);
      if (rnd_ready) out_ready = ($urandom % 4) != 0;
      #1;
      acc = in_valid && in_ready;
      observe();
      @(negedge clk);
   endtask

   task automatic put(logic [15:0] a, logic [15:0] b, logic [15:0] c,
                      bit fi, bit la);
      bit acc;
      in_valid = 1'b1; a_word = a; b_word = b; c_word = c;
      first_word = fi; last_word = la;
      do step(acc); while (!acc);
      in_valid = 1'b0;
   endtask

   task automatic idle(int n);
      bit acc;
      in_valid = 1'b0;
      for (int i = 0; i < n; i++) step(acc);
   endtask

   task automatic defaults();
      func = 8'hF0; use_a = 1; use_b = 1; use_c = 1;
      hold_a = '0; hold_b = '0; hold_c = '0;
      a_shift = '0; b_shift = '0; descend = 0;
      first_mask = 16'hFFFF; last_mask = 16'hFFFF;
   endtask

   initial begin : watchdog
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] named [6];
      named = '{8'h00, 8'hFF, 8'hF0, 8'hCC, 8'hAA, 8'hCA};
      rst_n = 0; in_valid = 0; out_ready = 1;
      first_word = 0; last_word = 0; a_word = '0; b_word = '0; c_word = '0;
      defaults();
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      check("R10 out_valid after reset", {15'h0, out_valid}, 16'h0);
      check("R10 in_ready after reset", {15'h0, in_ready}, 16'h1);
      @(negedge clk);

      cur_tag = "R2";
      foreach (named[i]) begin
         func = named[i];
         put(16'h0FF0, 16'h3C3C, 16'h5A5A, 1, 1);
      end

      cur_tag = "R1";
      for (int k = 0; k < 8; k++) begin
         func = 8'(1 << k);
         put(16'hFF00, 16'hF0F0, 16'hCCCC, 1, 1);
      end

      cur_tag = "R3";
      func = 8'hF0; a_shift = 4;
      put(16'h1234, 16'h0, 16'h0, 1, 0);
      put(16'hABCD, 16'h0, 16'h0, 0, 0);
      put(16'h0000, 16'h0, 16'h0, 0, 1);
      func = 8'hCC; b_shift = 7; a_shift = 2;
      put(16'h0, 16'h8001, 16'h0, 1, 0);
      put(16'h0, 16'hFFFF, 16'h0, 0, 1);

      cur_tag = "R4";
      put(16'h0, 16'h0F0F, 16'h0, 1, 1);
      func = 8'hF0;
      put(16'hFFFF, 16'h0, 16'h0, 1, 0);
      put(16'h0000, 16'h0, 16'h0, 0, 1);

      cur_tag = "R5";
      defaults(); descend = 1; a_shift = 5;
      put(16'h8421, 16'h0, 16'h0, 1, 0);
      put(16'hF00F, 16'h0, 16'h0, 0, 0);
      put(16'h0000, 16'h0, 16'h0, 0, 1);
      func = 8'hCC; b_shift = 9;
      put(16'h0, 16'hC003, 16'h0, 1, 0);
      put(16'h0, 16'h0000, 16'h0, 0, 1);

      cur_tag = "R6";
      defaults(); first_mask = 16'h0FFF; last_mask = 16'hFFF0;
      put(16'hFFFF, 16'h0, 16'h0, 1, 0);
      put(16'hFFFF, 16'h0, 16'h0, 0, 0);
      put(16'hFFFF, 16'h0, 16'h0, 0, 1);
      put(16'hFFFF, 16'h0, 16'h0, 1, 1);
      a_shift = 6; last_mask = 16'h0000;
      put(16'hFFFF, 16'h0, 16'h0, 1, 0);
      put(16'hFFFF, 16'h0, 16'h0, 0, 1);

      cur_tag = "R7";
      defaults(); func = 8'hAA; a_shift = 3; b_shift = 11;
      put(16'hFFFF, 16'hAAAA, 16'h1357, 1, 0);
      descend = 1;
      put(16'h5555, 16'hFFFF, 16'hBEEF, 0, 1);

      cur_tag = "R8";
      defaults(); func = 8'hCA;
      use_a = 0; hold_a = 16'hFF00;
      put(16'h00FF, 16'h1234, 16'h5678, 1, 1);
      use_a = 1; use_b = 0; hold_b = 16'hA5A5;
      put(16'hF0F0, 16'h0000, 16'h3333, 1, 1);
      use_b = 1; use_c = 0; hold_c = 16'hC3C3; func = 8'hAA;
      put(16'h0, 16'h0, 16'hFFFF, 1, 1);
      func = 8'hCA;
      put(16'h0FF0, 16'hFFFF, 16'h0000, 1, 1);

      cur_tag = "R9";
      defaults();
      out_ready = 0;
      in_valid = 1; a_word = 16'h4321; first_word = 1; last_word = 1;
      begin
         bit acc;
         step(acc); step(acc); step(acc); step(acc);
      end
      out_ready = 1;
      idle(2);
      rnd_ready = 1;
      for (int r = 0; r < 120; r++) begin
         int len;
         len = 1 + ($urandom % 4);
         func = 8'($urandom); descend = 1'($urandom);
         a_shift = 4'($urandom); b_shift = 4'($urandom);
         use_a = ($urandom % 5) != 0; use_b = ($urandom % 5) != 0;
         use_c = ($urandom % 5) != 0;
         hold_a = 16'($urandom); hold_b = 16'($urandom); hold_c = 16'($urandom);
         first_mask = 16'($urandom); last_mask = 16'($urandom);
         for (int w = 0; w < len; w++)
            put(16'($urandom), 16'($urandom), 16'($urandom), w == 0, w == len - 1);
         if ($urandom % 3 == 0) idle(1);
      end
      rnd_ready = 0; out_ready = 1;
      idle(4);
      check("R9 drained", 16'(exp_q.size()), 16'h0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule